// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block lets a host reach packet buffer memory one byte at a time through a small banked register window. A bank register, written at a fixed offset that every bank sees, decides how the remaining offsets are decoded. In the packet bank, two offsets load a 16-bit pointer one byte at a time, and four consecutive offsets form a data window. Every read or write through that window lands in one byte of packet memory.

Two flag bits in the pointer control each data access. The top bit chooses the target buffer: either the buffer at the head of the receive queue or the buffer named by the host packet number. The next bit chooses how the byte is addressed. In auto-increment mode, every access uses the current 11-bit offset and then steps that offset by one, wrapping within the buffer. In lane mode, the pointer stays put and the low two bits of the window offset are added to it. The receive-queue head and the packet number arrive on input ports from allocation logic outside this block. The buffers are synchronous RAM held inside the block, with one RAM for each buffer.

Top module: `pkt_window_port`

## Requirements
- R1: After reset, the bank register reads 0, the pointer is 0 and `host_rvalid` is low.
- R2: A write to offset 14 loads the bank register from `host_wdata`, in any bank. A read of offset 14 returns the bank register. A write to offset 15 changes nothing.
- R3: When the bank register holds 2, a write to offset 6 loads pointer bits 7:0 and a write to offset 7 loads pointer bits 15:8. Reads of offsets 6 and 7 return those bytes. In any other bank, writes to offsets 6 and 7 leave the pointer unchanged.
- R4: In bank 2, writes to offsets 3, 4 and 5 change neither the pointer, the bank register nor packet memory.
- R5: On a data access, pointer bit 15 = 1 targets the buffer given by `rxq_head`. Pointer bit 15 = 0 targets the buffer given by `pkt_num`.
- R6: In bank 2, with pointer bit 14 = 1, a data-window access (offsets 8 to 11) uses byte offset pointer[10:0] and ignores the window lane. Afterwards pointer[10:0] becomes (pointer[10:0] + 1) mod 2048, and pointer[15:11] is kept.
- R7: In bank 2, with pointer bit 14 = 0, a data-window access uses byte offset (pointer[10:0] + offset[1:0]) mod 2048 and leaves the pointer unchanged.
- R8: A read with `host_rd` = 1 and `host_wr` = 0 raises `host_rvalid` for exactly the next cycle, with the addressed data on `host_rdata`. A data-window read follows the same buffer, offset and increment rules as a write. In every other cycle, `host_rvalid` is low.
- R9: When `host_wr` and `host_rd` are both high, only the write takes place. `host_rvalid` stays low in the following cycle.
- R10: Data-window offsets 8 to 11 in a bank other than 2 leave packet memory and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 4 | Register window offset |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid while host_rvalid is high |
| host_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| rxq_head | input | SEL_W | Buffer index at the head of the receive queue |
| pkt_num | input | SEL_W | Buffer index chosen by the host packet number |

## Verification
Every read result is due in the cycle after its strobe is sampled. Pointer and bank updates show on the strobe edge itself, so the next access already uses the new value. The driver presents each access at a falling edge and pushes the expected byte, worked out from a byte-level model of the requirements, at that moment. The monitor pops and compares at the following falling edge, when `host_rvalid` must be high. It treats any valid cycle with no expectation waiting, and any expectation still left once a sequence drains, as a failure.

// File: rtl/pwp_pkg.sv
// Package: constants and types shared by the packet data port.
// Assumes a fixed 16-bit pointer whose flag positions are part of the
// host-visible behaviour.
package pwp_pkg;

    localparam int DATA_W       = 8;
    localparam int PTR_W        = 16;
    localparam int OFF_W        = 11;
    localparam int PTR_RXQ_BIT  = 15;
    localparam int PTR_AINC_BIT = 14;

    localparam logic [3:0]        OFS_BANK   = 4'd14;
    localparam logic [3:0]        OFS_PTR_LO = 4'd6;
    localparam logic [3:0]        OFS_PTR_HI = 4'd7;
    localparam logic [1:0]        OFS_WIN_HI = 2'b10;
    localparam logic [DATA_W-1:0] BANK_PKT   = 8'd2;

    // Decoded kind of the current host access.
    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_BANK,
        ACC_PTR_LO,
        ACC_PTR_HI,
        ACC_DATA
    } acc_e;

endpackage

// File: rtl/pwp_host_decode.sv
// Module: pwp_host_decode
// Classifies a host strobe against the bank register. Offset 14 is decoded
// in every bank. Offset 15 and unmapped offsets decode to ACC_NONE. A write
// strobe wins over a read strobe given in the same cycle.
module pwp_host_decode
    import pwp_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [3:0]        addr,
    input  logic [DATA_W-1:0] bank,
    output acc_e              kind,
    output logic              wr_go,
    output logic              rd_go,
    output logic [1:0]        lane
);

    // Pick the register or window the offset refers to.
    always_comb begin
        kind = ACC_NONE;
        if (addr == OFS_BANK) begin
            kind = ACC_BANK;
        end else if (bank == BANK_PKT) begin
            if (addr == OFS_PTR_LO) begin
                kind = ACC_PTR_LO;
            end else if (addr == OFS_PTR_HI) begin
                kind = ACC_PTR_HI;
            end else if (addr[3:2] == OFS_WIN_HI) begin
                kind = ACC_DATA;
            end
        end
    end

    // Settle strobe priority: the write proceeds, a colliding read is dropped.
    always_comb begin
        wr_go = wr_en;
        rd_go = rd_en && !wr_en;
    end

    // Byte lane within the data window.
    always_comb begin
        lane = addr[1:0];
    end

endmodule

// File: rtl/pwp_bank_reg.sv
// Module: pwp_bank_reg
// Holds the bank number that steers decode of the register window.
// Assumes the write is already qualified by the decoder.
module pwp_bank_reg
    import pwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bank_q
);

    // Load a new bank number, clearing it to 0 on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else if (load) begin
            bank_q <= wdata;
        end
    end

endmodule

// File: rtl/pwp_ptr_unit.sv
// Module: pwp_ptr_unit
// Owns the 16-bit data pointer. Works out which buffer and byte a data
// access targets, and steps the 11-bit offset in auto-increment mode.
// Assumes that at most one of the load strobes and data_acc is high in a
// cycle, which the decoder guarantees.
module pwp_ptr_unit
    import pwp_pkg::*;
#(
    parameter int SEL_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              data_acc,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  rxq_head,
    input  logic [SEL_W-1:0]  pkt_num,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [SEL_W-1:0]  buf_sel,
    output logic [OFF_W-1:0]  byte_off
);

    logic             ainc;
    logic [OFF_W-1:0] off_next;

    // Pull the mode flag out of the pointer and form the wrapped successor.
    always_comb begin
        ainc     = ptr_q[PTR_AINC_BIT];
        off_next = ptr_q[OFF_W-1:0] + OFF_W'(1);
    end

    // Choose the target buffer from the queue-select flag.
    always_comb begin
        buf_sel = ptr_q[PTR_RXQ_BIT] ? rxq_head : pkt_num;
    end

    // Byte offset: the bare pointer in auto-increment mode, pointer plus lane otherwise.
    always_comb begin
        if (ainc) begin
            byte_off = ptr_q[OFF_W-1:0];
        end else begin
            byte_off = ptr_q[OFF_W-1:0] + OFF_W'(lane);
        end
    end

    // Load pointer bytes from the host, or advance the offset after a data access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_lo) begin
            ptr_q[7:0] <= wdata;
        end else if (load_hi) begin
            ptr_q[15:8] <= wdata;
        end else if (data_acc && ainc) begin
            ptr_q[OFF_W-1:0] <= off_next;
        end
    end

endmodule

// File: rtl/pwp_buf_ram.sv
// Module: pwp_buf_ram
// One packet buffer: a single-port synchronous RAM with a registered read
// port. Assumes the caller never raises we and re together.
module pwp_buf_ram #(
    parameter int DEPTH = 2048,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Store a host byte.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    // Register the byte read out.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/pkt_window_port.sv
// Module: pkt_window_port
// Top of the pointer-addressed packet data port. Decodes host strobes
// against the bank register, updates the pointer, and reads or writes one
// byte of the selected buffer RAM. Read data comes back one cycle after the
// read strobe, with host_rvalid high. Assumes buffer indices from the
// allocation logic stay stable during the cycle they are used.
module pkt_window_port
    import pwp_pkg::*;
#(
    parameter int BUF_CNT   = 2,
    parameter int BUF_BYTES = 2048,
    parameter int SEL_W     = (BUF_CNT > 1) ? $clog2(BUF_CNT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [3:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    input  logic [SEL_W-1:0]  rxq_head,
    input  logic [SEL_W-1:0]  pkt_num
);

    localparam int RAM_AW = $clog2(BUF_BYTES);

    acc_e              kind;
    logic              wr_go;
    logic              rd_go;
    logic [1:0]        lane;
    logic [DATA_W-1:0] bank_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [SEL_W-1:0]  buf_sel;
    logic [OFF_W-1:0]  byte_off;
    logic              is_data;
    logic              mem_we;
    logic              mem_re;
    logic [DATA_W-1:0] reg_view;
    logic [DATA_W-1:0] reg_rdata_q;
    logic              src_mem_q;
    logic [SEL_W-1:0]  sel_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] ram_rdata [BUF_CNT];

    pwp_host_decode u_dec (
        .wr_en (host_wr),
        .rd_en (host_rd),
        .addr  (host_addr),
        .bank  (bank_q),
        .kind  (kind),
        .wr_go (wr_go),
        .rd_go (rd_go),
        .lane  (lane)
    );

    pwp_bank_reg u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (wr_go && (kind == ACC_BANK)),
        .wdata  (host_wdata),
        .bank_q (bank_q)
    );

    // Flag a data-window access and split it into RAM write and read.
    always_comb begin
        is_data = (kind == ACC_DATA);
        mem_we  = wr_go && is_data;
        mem_re  = rd_go && is_data;
    end

    pwp_ptr_unit #(
        .SEL_W (SEL_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_lo  (wr_go && (kind == ACC_PTR_LO)),
        .load_hi  (wr_go && (kind == ACC_PTR_HI)),
        .data_acc (mem_we || mem_re),
        .lane     (lane),
        .wdata    (host_wdata),
        .rxq_head (rxq_head),
        .pkt_num  (pkt_num),
        .ptr_q    (ptr_q),
        .buf_sel  (buf_sel),
        .byte_off (byte_off)
    );

    // One RAM per buffer. Only the selected buffer sees the strobe.
    for (genvar g = 0; g < BUF_CNT; g++) begin : g_buf
        logic hit;
        assign hit = (buf_sel == SEL_W'(g));
        pwp_buf_ram #(
            .DEPTH (BUF_BYTES),
            .DW    (DATA_W)
        ) u_ram (
            .clk   (clk),
            .we    (mem_we && hit),
            .re    (mem_re && hit),
            .addr  (byte_off[RAM_AW-1:0]),
            .wdata (host_wdata),
            .rdata (ram_rdata[g])
        );
    end

    // Value a register read returns, chosen by the decoded kind.
    always_comb begin
        case (kind)
            ACC_BANK:   reg_view = bank_q;
            ACC_PTR_LO: reg_view = ptr_q[7:0];
            ACC_PTR_HI: reg_view = ptr_q[15:8];
            default:    reg_view = '0;
        endcase
    end

    // Record where this cycle's read gets its data, so the result lines up with the RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q    <= 1'b0;
            src_mem_q   <= 1'b0;
            sel_q       <= '0;
            reg_rdata_q <= '0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) begin
                src_mem_q   <= is_data;
                sel_q       <= buf_sel;
                reg_rdata_q <= reg_view;
            end
        end
    end

    // Put the RAM byte or the register byte on the read bus.
    always_comb begin
        host_rvalid = rvalid_q;
        host_rdata  = src_mem_q ? ram_rdata[sel_q] : reg_rdata_q;
    end

endmodule

// File: rtl/pwp_checker.sv
// Module: pwp_checker
// Temporal checks on the packet data port, bound to its top module.
// Looks at host strobes, the bank register and the pointer.
module pwp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic        host_rd,
    input logic [3:0]  host_addr,
    input logic [7:0]  bank_q,
    input logic [15:0] ptr_q,
    input logic        host_rvalid
);

    logic win_acc;
    logic ign_wr;

    // Work out from the ports which strobes hit the window and which are ignored.
    always_comb begin
        win_acc = (host_wr || host_rd) && (bank_q == 8'd2) && (host_addr[3:2] == 2'b10);
        ign_wr  = host_wr && (bank_q == 8'd2) && (host_addr >= 4'd3) && (host_addr <= 4'd5);
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid); // R8

    AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> !host_rvalid); // R9

    AST_AINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && ptr_q[14]) |=>
            (ptr_q[15:11] == $past(ptr_q[15:11])) &&
            (ptr_q[10:0] == 11'($past(ptr_q[10:0]) + 11'd1))); // R6

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_acc && !ptr_q[14]) |=> $stable(ptr_q)); // R7

    AST_OFS15_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 4'd15) |=> $stable(bank_q)); // R2

    AST_RO_OFS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ign_wr |=> ($stable(ptr_q) && $stable(bank_q))); // R4

    AST_PTR_OTHER_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && bank_q != 8'd2 && host_addr != 4'd14) |=> $stable(ptr_q)); // R10

endmodule

bind pkt_window_port pwp_checker u_pwp_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_addr   (host_addr),
    .bank_q      (bank_q),
    .ptr_q       (ptr_q),
    .host_rvalid (host_rvalid)
);

// File: tb/pkt_window_port_tb_top.sv
// Bench for pkt_window_port. A driver pushes expected read bytes into a
// scoreboard queue, and a monitor pops and compares them as results appear.
module pkt_window_port_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       host_rvalid;
    logic [0:0] rxq_head = '0;
    logic [0:0] pkt_num = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    logic [7:0]  m_bank = '0;
    logic [15:0] m_ptr = '0;
    logic [7:0]  ref_mem [int];

    always #2 clk = ~clk;

    pkt_window_port dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .host_rd     (host_rd),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid),
        .rxq_head    (rxq_head),
        .pkt_num     (pkt_num)
    );

    function automatic bit is_win(input logic [3:0] a);
        return (m_bank == 8'd2) && (a >= 4'd8) && (a <= 4'd11);
    endfunction

    function automatic int win_key(input logic [3:0] a);
        logic [10:0] off;
        int          b;
        off = m_ptr[14] ? m_ptr[10:0] : 11'(m_ptr[10:0] + 11'(a[1:0]));
        b   = m_ptr[15] ? int'(rxq_head) : int'(pkt_num);
        return b * 2048 + int'(off);
    endfunction

    function automatic void step_ptr();
        if (m_ptr[14]) m_ptr[10:0] = m_ptr[10:0] + 11'd1;
    endfunction

    function automatic void model_write(input logic [3:0] a, input logic [7:0] d);
        if (a == 4'd14) begin
            m_bank = d;
        end else if (m_bank == 8'd2) begin
            if (a == 4'd6) m_ptr[7:0] = d;
            else if (a == 4'd7) m_ptr[15:8] = d;
            else if (is_win(a)) begin
                ref_mem[win_key(a)] = d;
                step_ptr();
            end
        end
    endfunction

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b0; host_addr = a; host_wdata = d;
        model_write(a, d);
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b1; host_addr = a;
        if (a == 4'd14) e = m_bank;
        else if (m_bank == 8'd2 && a == 4'd6) e = m_ptr[7:0];
        else if (m_bank == 8'd2 && a == 4'd7) e = m_ptr[15:8];
        else if (is_win(a)) begin
            e = ref_mem.exists(win_key(a)) ? ref_mem[win_key(a)] : 8'h00;
            step_ptr();
        end else e = 8'h00;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic wr_rd(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_rd = 1'b1; host_addr = a; host_wdata = d;
        model_write(a, d);
        @(posedge clk); #1;
        host_wr = 1'b0; host_rd = 1'b0;
        @(negedge clk);
        checks++;
        if (host_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R9 rvalid after collision: actual %b expected 0", host_rvalid);
        end
    endtask

    task automatic set_ptr(input logic [15:0] p);
        wr(4'd6, p[7:0]);
        wr(4'd7, p[15:8]);
    endtask

    task automatic drain(input string tag);
        @(negedge clk); #1;
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing read results: actual %0d pending expected 0", tag, exp_q.size());
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // Monitor: compare each valid result with the front of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done && host_rvalid === 1'b1) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected rvalid: actual data %h expected no result", host_rdata);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (host_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", t, host_rdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (host_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rvalid in reset: actual %b expected 0", host_rvalid);
        end
        rst_n = 1'b1;

        // R1: reset values
        rd(4'd14, "R1 bank after reset");
        wr(4'd14, 8'd2);
        rd(4'd6, "R1 ptr lo after reset");
        rd(4'd7, "R1 ptr hi after reset");
        drain("R1");

        // R2: offset 15 ignored, offset 14 loads bank
        wr(4'd14, 8'd0);
        wr(4'd15, 8'd2);
        rd(4'd14, "R2 bank after offset 15 write");
        wr(4'd14, 8'd2);
        rd(4'd14, "R2 bank after offset 14 write");
        drain("R2");

        // R3: pointer bytes and other-bank isolation
        set_ptr(16'h1234);
        rd(4'd6, "R3 ptr lo");
        rd(4'd7, "R3 ptr hi");
        wr(4'd14, 8'd1);
        wr(4'd6, 8'hFF);
        wr(4'd7, 8'hFF);
        wr(4'd14, 8'd2);
        rd(4'd6, "R3 ptr lo after bank1 write");
        rd(4'd7, "R3 ptr hi after bank1 write");
        drain("R3");

        // R7: lane addressing, pointer fixed, packet-number buffer
        pkt_num = 1'b1;
        set_ptr(16'h0010);
        wr(4'd8, 8'hAA);
        wr(4'd9, 8'hBB);
        wr(4'd10, 8'hCC);
        wr(4'd11, 8'hDD);
        rd(4'd6, "R7 ptr lo unchanged");
        rd(4'd11, "R7 lane 3 read");
        rd(4'd8, "R7 lane 0 read");
        rd(4'd10, "R7 lane 2 read");
        rd(4'd7, "R7 ptr hi unchanged");
        drain("R7");

        // R4: writes to offsets 3..5 ignored
        wr(4'd3, 8'h55);
        wr(4'd4, 8'h66);
        wr(4'd5, 8'h77);
        rd(4'd6, "R4 ptr lo after ignored writes");
        rd(4'd14, "R4 bank after ignored writes");
        rd(4'd9, "R4 memory after ignored writes");
        drain("R4");

        // R6: auto-increment with wrap, back-to-back reads
        set_ptr(16'h47FE);
        wr(4'd8, 8'h11);
        wr(4'd9, 8'h22);
        wr(4'd8, 8'h33);
        rd(4'd6, "R6 ptr lo after wrap");
        rd(4'd7, "R6 ptr hi kept after wrap");
        set_ptr(16'h47FE);
        rd(4'd8, "R6 read 0x7FE");
        rd(4'd11, "R6 read 0x7FF lane ignored");
        rd(4'd8, "R6 read wrapped 0x000");
        rd(4'd6, "R6 ptr lo after reads");
        drain("R6");

        // R5: receive-queue head versus packet number
        rxq_head = 1'b0;
        set_ptr(16'hC100);
        wr(4'd10, 8'h99);
        set_ptr(16'h8100);
        rd(4'd8, "R5 rxq buffer 0 read");
        set_ptr(16'h8010);
        wr(4'd9, 8'h5A);
        set_ptr(16'h0010);
        rd(4'd9, "R5 pkt_num buffer 1 read");
        set_ptr(16'h8010);
        rd(4'd9, "R5 rxq buffer 0 read");
        rxq_head = 1'b1;
        rd(4'd9, "R5 rxq follows head index");
        drain("R5");

        // R9: write and read together, only the write happens
        set_ptr(16'h0020);
        wr_rd(4'd8, 8'h77);
        rd(4'd8, "R9 collided write landed");
        drain("R9");

        // R10: data window outside bank 2
        wr(4'd14, 8'd0);
        wr(4'd8, 8'hEE);
        wr(4'd14, 8'd3);
        rd(4'd8, "R10 bank3 window reads 0");
        wr(4'd14, 8'd2);
        rd(4'd8, "R10 memory after bank0 write");
        rd(4'd6, "R10 ptr after bank0 write");
        drain("R10");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule